// File: doc/BRIEF.md
# Power-to-Pulse Rate Converter

This block turns a stream of signed real-power samples, one word per phase of a three-phase supply, into logic pulse trains whose rate follows the power. The three words on each sample strobe are added into one total. The total is fed into two accumulators, each of which emits an event every time its running magnitude reaches a threshold. After each event the threshold is taken out, and the residue carries over to the next sample.

The slow accumulator drives a pair of outputs that take turns. Each event goes to the pin that did not fire last, so the two pins can drive a two-phase stepper counter directly. The fast accumulator drives a calibration output. Its pulse width is nominal in the normal rate mode and very short in the fast rate mode. Every output shortens its pulse to half of its measured period when the period is too short for the nominal width.

A reverse-power flag shows whether the latest sample had a negative phase. The flag changes only at the moment a calibration pulse starts. A low reset or a low supply-good input clears all accumulators and keeps every output low.

Top module: `pwr_pulse_conv`

## Requirements
- R1: While `rst_n` or `supply_ok` is low at a rising clock edge, all four outputs are low after that edge and both accumulators are cleared. After `supply_ok` returns with a constant total S on every cycle, the first `cal_out` pulse rises at the edge that follows the sample bringing the accumulated total to FAST_TH, which is the (FAST_TH/|S|+1)-th edge.
- R2: On each `smp_valid` the sum of the three phase words is added to the fast accumulator. `cal_out` emits one pulse each time the magnitude reaches FAST_TH, and the residue carries over. With a constant total, the `cal_out` period is FAST_TH/|S| cycles.
- R3: Slow events alternate between the two pins, starting with `slow_a` after a clear. Each pin has a period of 2·SLOW_TH/|S| cycles, and `slow_b` falls half of that period after `slow_a` falls.
- R4: When a slow pin's period is at least twice SLOW_W, its pulse is high for SLOW_W cycles.
- R5: With `cal_fast` low and a `cal_out` period of at least twice CF_W, each `cal_out` pulse is high for CF_W cycles.
- R6: With `cal_fast` high, each `cal_out` pulse is high for FAST_W cycles.
- R7: When an output's measured period P is less than twice its nominal width, the pulse is high for P/2 cycles, rounded down, with a minimum of 1.
- R8: `rev_flag` takes the value "some phase word of the latest sample is negative" and changes only on the edge where `cal_out` rises.
- R9: A negative total produces pulses at the rate set by its magnitude.
- R10: Phase words presented while `smp_valid` is low are not accumulated and produce no pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| supply_ok | input | 1 | Supply-good; low holds the block cleared |
| smp_valid | input | 1 | Strobe marking a new set of phase words |
| pwr_a | input | PWR_W | Signed power, phase A |
| pwr_b | input | PWR_W | Signed power, phase B |
| pwr_c | input | PWR_W | Signed power, phase C |
| cal_fast | input | 1 | Calibration rate mode: 1 selects the short width |
| slow_a | output | 1 | First alternating slow pulse output |
| slow_b | output | 1 | Second alternating slow pulse output |
| cal_out | output | 1 | Calibration pulse output |
| rev_flag | output | 1 | Reverse-power indicator |

## Verification
Some properties hold on every cycle, and the assertions cover them:
- every output pulse starts only on a trigger;
- the outputs go quiet the cycle after supply loss;
- `rev_flag` moves only together with a rising `cal_out`;
- each accumulator's residue stays strictly inside its threshold.

Other properties only show across a whole pulse train, so only the bench scenarios can show them:
- the pulse periods, the half-period offset between the slow pins, and the pin taking the first event after a clear;
- the widths in the nominal, fast and shortened cases;
- that unstrobed words are ignored.

// File: rtl/pwr_pulse_pkg.sv
`timescale 1ns/1ps
// Shared types for the power-to-pulse converter.
package pwr_pulse_pkg;
    // Which slow pin takes the next accumulator event.
    typedef enum logic {
        PIN_A = 1'b0,
        PIN_B = 1'b1
    } slow_pin_e;
endpackage

// File: rtl/pwr_phase_sum.sv
`timescale 1ns/1ps
// Adds three signed phase words into one total and reports whether any
// phase is negative.
// Assumes: two's complement inputs; the output is two bits wider, so the
// sum cannot overflow.
module pwr_phase_sum #(
    parameter int PWR_W = 24,
    localparam int SUM_W = PWR_W + 2
) (
    input  logic signed [PWR_W-1:0] ph_a,
    input  logic signed [PWR_W-1:0] ph_b,
    input  logic signed [PWR_W-1:0] ph_c,
    output logic signed [SUM_W-1:0] total,
    output logic                    any_neg
);
    // Sign-extended sum and sign detection.
    always_comb begin
        total   = SUM_W'(ph_a) + SUM_W'(ph_b) + SUM_W'(ph_c);
        any_neg = ph_a[PWR_W-1] | ph_b[PWR_W-1] | ph_c[PWR_W-1];
    end
endmodule

// File: rtl/pwr_accum.sv
`timescale 1ns/1ps
// Signed accumulator with a magnitude threshold. On each strobe it adds the
// total. When the result reaches +THRESH or -THRESH it takes the threshold
// off toward zero and raises a one-cycle event.
// Assumes: |total| < THRESH, so at most one event per sample.
module pwr_accum #(
    parameter int    SUM_W  = 26,
    parameter int    ACC_W  = 32,
    parameter longint THRESH = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid,
    input  logic signed [SUM_W-1:0] total,
    output logic                    event_q
);
    localparam logic signed [ACC_W-1:0] TH_P = ACC_W'(THRESH);
    localparam logic signed [ACC_W-1:0] TH_N = -TH_P;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] nxt_c;

    // Candidate value after adding this sample.
    always_comb nxt_c = acc_q + ACC_W'(total);

    // Accumulate, take off the threshold, flag the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q   <= '0;
            event_q <= 1'b0;
        end else if (valid) begin
            if (nxt_c >= TH_P) begin
                acc_q   <= nxt_c - TH_P;
                event_q <= 1'b1;
            end else if (nxt_c <= TH_N) begin
                acc_q   <= nxt_c + TH_P;
                event_q <= 1'b1;
            end else begin
                acc_q   <= nxt_c;
                event_q <= 1'b0;
            end
        end else begin
            event_q <= 1'b0;
        end
    end

    // R2: residue stays strictly within the threshold
    a_r2_residue_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_q < TH_P) && (acc_q > TH_N));
endmodule

// File: rtl/pwr_pulse_shaper.sv
`timescale 1ns/1ps
// Turns trigger events into pulses. It measures the gap between triggers.
// The width is the nominal one unless the last period is under twice the
// nominal width; then it is half the period, with a minimum of one cycle.
// Assumes: nom_w >= 1; the gap counter saturates on long periods.
module pwr_pulse_shaper #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [CNT_W-1:0] nom_w,
    output logic             pulse
);
    localparam logic [CNT_W-1:0] GAP_MAX = '1;

    logic [CNT_W-1:0] gap_q;
    logic [CNT_W-1:0] left_q;
    logic [CNT_W-1:0] width_c;
    logic [CNT_W:0]   per_c;

    // Choose the width for a trigger arriving now.
    always_comb begin
        per_c = {1'b0, gap_q} + 1'b1;
        if (per_c < {nom_w, 1'b0}) begin
            width_c = per_c[CNT_W:1];
            if (width_c == '0) width_c = CNT_W'(1);
        end else begin
            width_c = nom_w;
        end
    end

    // Cycles since the last trigger, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || trig) gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    // Hold the pulse high for the chosen width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse  <= 1'b0;
            left_q <= '0;
        end else if (trig) begin
            pulse  <= 1'b1;
            left_q <= width_c - 1'b1;
        end else if (left_q != '0) begin
            left_q <= left_q - 1'b1;
        end else begin
            pulse <= 1'b0;
        end
    end

    // R7: a pulse starts only from a trigger
    a_r7_rise_needs_trig: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse) |-> $past(trig));
endmodule

// File: rtl/pwr_pulse_conv.sv
`timescale 1ns/1ps
// Top of the power-to-pulse converter. It sums the phase words and feeds a
// slow accumulator, whose events alternate between two pins, and a fast
// accumulator driving the calibration output. It also keeps the reverse
// flag, which changes only when a calibration pulse starts.
// Assumes: |sum| < each threshold; thresholds and widths are in clock cycles.
module pwr_pulse_conv #(
    parameter int     PWR_W   = 24,
    parameter int     ACC_W   = 32,
    parameter longint SLOW_TH = 64'd268435456,
    parameter longint FAST_TH = 64'd4194304,
    parameter int     CNT_W   = 24,
    parameter int     SLOW_W  = 2750000,
    parameter int     CF_W    = 900000,
    parameter int     FAST_W  = 10
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    supply_ok,
    input  logic                    smp_valid,
    input  logic signed [PWR_W-1:0] pwr_a,
    input  logic signed [PWR_W-1:0] pwr_b,
    input  logic signed [PWR_W-1:0] pwr_c,
    input  logic                    cal_fast,
    output logic                    slow_a,
    output logic                    slow_b,
    output logic                    cal_out,
    output logic                    rev_flag
);
    import pwr_pulse_pkg::*;

    localparam int SUM_W = PWR_W + 2;
    localparam logic [CNT_W-1:0] SLOW_NOM = CNT_W'(SLOW_W);
    localparam logic [CNT_W-1:0] CF_NOM   = CNT_W'(CF_W);
    localparam logic [CNT_W-1:0] FAST_NOM = CNT_W'(FAST_W);

    logic                    run_n;
    logic signed [SUM_W-1:0] total;
    logic                    any_neg;
    logic                    neg_q;
    logic                    rev_q;
    logic                    slow_ev;
    logic                    fast_ev;
    slow_pin_e               next_pin_q;
    logic [1:0]              slow_trig;
    logic [CNT_W-1:0]        cf_nom;

    assign run_n  = rst_n & supply_ok;
    assign cf_nom = cal_fast ? FAST_NOM : CF_NOM;

    pwr_phase_sum #(.PWR_W(PWR_W)) sum_i (
        .ph_a(pwr_a), .ph_b(pwr_b), .ph_c(pwr_c),
        .total(total), .any_neg(any_neg)
    );

    pwr_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W), .THRESH(SLOW_TH)) slow_acc_i (
        .clk(clk), .rst_n(run_n), .valid(smp_valid),
        .total(total), .event_q(slow_ev)
    );

    pwr_accum #(.SUM_W(SUM_W), .ACC_W(ACC_W), .THRESH(FAST_TH)) fast_acc_i (
        .clk(clk), .rst_n(run_n), .valid(smp_valid),
        .total(total), .event_q(fast_ev)
    );

    // Route each slow event to the pin whose turn it is.
    always_comb begin
        slow_trig[0] = slow_ev && (next_pin_q == PIN_A);
        slow_trig[1] = slow_ev && (next_pin_q == PIN_B);
    end

    // Alternate pins on every slow event.
    always_ff @(posedge clk) begin
        if (!run_n)       next_pin_q <= PIN_A;
        else if (slow_ev) next_pin_q <= (next_pin_q == PIN_A) ? PIN_B : PIN_A;
    end

    logic [1:0] slow_pulse;
    for (genvar g = 0; g < 2; g++) begin : g_slow
        pwr_pulse_shaper #(.CNT_W(CNT_W)) shp_i (
            .clk(clk), .rst_n(run_n), .trig(slow_trig[g]),
            .nom_w(SLOW_NOM), .pulse(slow_pulse[g])
        );
    end
    assign slow_a = slow_pulse[0];
    assign slow_b = slow_pulse[1];

    pwr_pulse_shaper #(.CNT_W(CNT_W)) cal_shp_i (
        .clk(clk), .rst_n(run_n), .trig(fast_ev),
        .nom_w(cf_nom), .pulse(cal_out)
    );

    // Remember the sign state of the latest sample.
    always_ff @(posedge clk) begin
        if (!run_n)         neg_q <= 1'b0;
        else if (smp_valid) neg_q <= any_neg;
    end

    // Reverse flag updates as a calibration pulse is issued.
    always_ff @(posedge clk) begin
        if (!run_n)       rev_q <= 1'b0;
        else if (fast_ev) rev_q <= neg_q;
    end
    assign rev_flag = rev_q;

    // R1: outputs quiet the cycle after supply loss
    a_r1_quiet_on_fail: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> (!slow_a && !slow_b && !cal_out));

    // R8: reverse flag moves only with a starting calibration pulse
    a_r8_rev_with_cal: assert property (@(posedge clk) disable iff (!run_n)
        (rev_flag != $past(rev_flag)) |-> $rose(cal_out));
endmodule

// File: tb/pwr_pulse_conv_tb_top.sv
`timescale 1ns/1ps
module pwr_pulse_conv_tb_top;
    localparam int CLK_PER = 10;
    localparam int PW      = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic smp_valid = 1'b0;
    logic signed [PW-1:0] pa = '0, pb = '0, pc = '0;
    logic cal_fast = 1'b0;
    logic slow_a, slow_b, cal_out, rev_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PER/2) clk = ~clk;

    pwr_pulse_conv #(
        .PWR_W(PW), .ACC_W(24), .SLOW_TH(5000), .FAST_TH(2500),
        .CNT_W(12), .SLOW_W(8), .CF_W(3), .FAST_W(1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .smp_valid(smp_valid),
        .pwr_a(pa), .pwr_b(pb), .pwr_c(pc), .cal_fast(cal_fast),
        .slow_a(slow_a), .slow_b(slow_b), .cal_out(cal_out), .rev_flag(rev_flag)
    );

    // Edge monitor: index 0 slow_a, 1 slow_b, 2 cal_out.
    int cyc = 0;
    int rise_t[3], fall_t[3], per[3], wid[3], npulse[3];
    logic prv[3];
    int ab_off = 0;
    initial for (int i = 0; i < 3; i++) begin
        rise_t[i] = 0; fall_t[i] = 0; per[i] = 0; wid[i] = 0; npulse[i] = 0; prv[i] = 1'b0;
    end
    always @(negedge clk) begin
        logic s [3];
        s[0] = slow_a; s[1] = slow_b; s[2] = cal_out;
        cyc++;
        for (int i = 0; i < 3; i++) begin
            if (s[i] && !prv[i]) begin
                per[i] = cyc - rise_t[i]; rise_t[i] = cyc; npulse[i]++;
            end
            if (!s[i] && prv[i]) begin
                wid[i] = cyc - rise_t[i];
                if (i == 1) ab_off = cyc - fall_t[0];
                fall_t[i] = cyc;
            end
            prv[i] = s[i];
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic set_pwr(input int a, input int b, input int c);
        pa = PW'(a); pb = PW'(b); pc = PW'(c);
    endtask

    task automatic t_reset();
        wait_cyc(5);
        chk_eq("R1 reset slow_a", int'(slow_a), 0);
        chk_eq("R1 reset slow_b", int'(slow_b), 0);
        chk_eq("R1 reset cal_out", int'(cal_out), 0);
        chk_eq("R8 reset rev_flag", int'(rev_flag), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_const();
        set_pwr(100, 100, 50); smp_valid = 1'b1;
        wait_cyc(200);
        chk_eq("R2 cal period", per[2], 10);
        chk_eq("R5 cal width", wid[2], 3);
        chk_eq("R3 slow_a period", per[0], 40);
        chk_eq("R3 slow_b period", per[1], 40);
        chk_eq("R3 b-after-a fall offset", ab_off, 20);
        chk_eq("R4 slow_a width", wid[0], 8);
        chk_eq("R4 slow_b width", wid[1], 8);
        chk_eq("R8 rev low for positive", int'(rev_flag), 0);
    endtask

    task automatic t_fast();
        cal_fast = 1'b1;
        wait_cyc(100);
        chk_eq("R6 fast cal width", wid[2], 1);
        chk_eq("R6 fast cal period", per[2], 10);
        cal_fast = 1'b0;
        wait_cyc(40);
    endtask

    task automatic t_shrink();
        set_pwr(500, 500, 250);
        wait_cyc(200);
        chk_eq("R7 short cal period", per[2], 2);
        chk_eq("R7 short cal width", wid[2], 1);
        chk_eq("R7 short slow_a period", per[0], 8);
        chk_eq("R7 short slow_a width", wid[0], 4);
        set_pwr(100, 100, 50);
        wait_cyc(200);
    endtask

    task automatic t_rev();
        logic prev_rev;
        logic prev_cal;
        prev_rev = rev_flag; prev_cal = cal_out;
        set_pwr(500, 500, -375);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rev_flag != prev_rev)
                chk(cal_out && !prev_cal, "R8 rev set only with cal rise", int'(cal_out), 1);
            prev_rev = rev_flag; prev_cal = cal_out;
        end
        chk_eq("R8 rev high after negative phase", int'(rev_flag), 1);
        chk_eq("R7 cal width period 4", wid[2], 2);
        set_pwr(100, 100, 50);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (rev_flag != prev_rev)
                chk(cal_out && !prev_cal, "R8 rev clear only with cal rise", int'(cal_out), 1);
            prev_rev = rev_flag; prev_cal = cal_out;
        end
        chk_eq("R8 rev clears when positive", int'(rev_flag), 0);
    endtask

    task automatic t_negtotal();
        set_pwr(-100, -100, -50);
        wait_cyc(200);
        chk_eq("R9 negative total cal period", per[2], 10);
        chk_eq("R9 negative total slow_a period", per[0], 40);
        chk_eq("R8 rev high for negative total", int'(rev_flag), 1);
        set_pwr(100, 100, 50);
        wait_cyc(100);
    endtask

    task automatic t_novalid();
        int n0, n2;
        smp_valid = 1'b0;
        set_pwr(1000, 200, 0);
        wait_cyc(20);
        n0 = npulse[0]; n2 = npulse[2];
        wait_cyc(100);
        chk_eq("R10 no cal pulses without strobe", npulse[2] - n2, 0);
        chk_eq("R10 no slow pulses without strobe", npulse[0] - n0, 0);
        chk_eq("R10 cal_out low", int'(cal_out), 0);
        set_pwr(100, 100, 50);
        smp_valid = 1'b1;
        wait_cyc(100);
    endtask

    task automatic t_supply();
        int loud, n, ra, rb;
        supply_ok = 1'b0;
        @(negedge clk);
        loud = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (slow_a || slow_b || cal_out || rev_flag) loud++;
        end
        chk_eq("R1 outputs quiet during supply fail", loud, 0);
        supply_ok = 1'b1;
        n = 0; ra = 0; rb = 0;
        for (int i = 1; i <= 60; i++) begin
            @(negedge clk);
            if (cal_out && n == 0) n = i;
            if (slow_a && ra == 0) ra = i;
            if (slow_b && rb == 0) rb = i;
        end
        chk_eq("R1 first cal pulse after restore", n, 11);
        chk_eq("R3 slow_a fires first after clear", ra, 21);
        chk_eq("R3 slow_b follows", rb, 41);
    endtask

    initial begin
        t_reset();
        t_const();
        t_fast();
        t_shrink();
        t_rev();
        t_negtotal();
        t_novalid();
        t_supply();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PER * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule